// File: doc/BRIEF.md
# Self-Sweeping LED Brightness Modulator

This block produces a fixed-rate pulse train on a small group of LED outputs and varies its duty cycle on its own, so the LEDs appear to glow brighter and then fade in an endless loop. It has no register interface and no data path. It needs only a clock and an active-low reset. Once out of reset it runs without pause, whatever the rest of the chip, including any processor, is doing.

A free-running carrier counter sets the pulse rate. With the default 11-bit counter and a 50 MHz clock, one carrier period is 2048 clocks, which is about 24.4 kHz. A prescaler counts carrier periods and issues one ramp step every `STEP_PERIODS` periods. The ramp holds a duty code from 0 to `2**DUTY_W`. It walks up to the top code and then back down to zero, one code per step, like a triangle wave. During each carrier period the outputs are high for the first `duty << (CNT_W-DUTY_W)` clocks and low for the rest. A code of zero keeps the outputs dark, and the top code keeps them lit. With the defaults (8-bit duty, 72 periods per step), one full bright-and-dim cycle takes about 1.5 s. All outputs carry the same waveform, which is registered once before the pins.

Top module: `breath_pwm`

## Requirements
- R1: While `rst_n` is low, every `led` bit is 0. After reset is released, the ramp restarts at duty code 0 in the rising direction.
- R2: The carrier period is exactly `2**CNT_W` clock cycles (2048 by default, which gives 24.4 kHz from 50 MHz).
- R3: At duty code 0, the outputs stay low for the whole carrier period.
- R4: At the top duty code `2**DUTY_W`, the outputs stay high for the whole carrier period.
- R5: Within a period at duty code d, the outputs are high for the first `d * 2**(CNT_W-DUTY_W)` clocks and low for the rest. They rise only at the start of a period, so there is one pulse per period and no runt pulses.
- R6: The duty code changes only at a carrier period boundary, and only once every `STEP_PERIODS` periods.
- R7: Each change of the duty code is exactly +1 or -1, and the code never exceeds `2**DUTY_W`. The code climbs from 0 to the top, then falls back to 0, then repeats. Each endpoint is visited once per turn (it is held for a single step) and is never skipped.
- R8: All `NUM_LED` outputs carry the same value on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the carrier period and sweep rate scale with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| led | output | NUM_LED | Modulated LED drive, active high, identical on all bits |

## Verification
The bound checker examines every cycle for the following:
- all outputs are equal;
- the outputs are dark during reset;
- the duty code stays fixed away from a period boundary;
- the code moves by one unit per change and stays within range;
- a rising output edge falls only on the first clock of a period.

The bench scoreboard shows what no single-cycle property can: the exact high and low pattern of every clock, period after period, across several full triangle sweeps. This covers the plateau length of `STEP_PERIODS` periods per code, the single visit to each endpoint, and the restart at code 0 after a mid-run reset.

// File: rtl/breath_pwm_pkg.sv
package breath_pwm_pkg;
  typedef enum logic {
    RAMP_DOWN = 1'b0,
    RAMP_UP   = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/breath_carrier.sv
// Free-running carrier counter; flags the last clock of each period.
module breath_carrier #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             period_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign period_end = &cnt;
endmodule

// File: rtl/breath_prescale.sv
// Counts carrier periods and emits one step strobe every STEP_PERIODS.
module breath_prescale #(
  parameter int STEP_PERIODS = 72
) (
  input  logic clk,
  input  logic rst_n,
  input  logic period_end,
  output logic step
);
  localparam int PW = (STEP_PERIODS > 1) ? $clog2(STEP_PERIODS) : 1;

  generate
    if (STEP_PERIODS <= 1) begin : g_direct
      assign step = period_end;
    end else begin : g_count
      localparam logic [PW-1:0] LAST = PW'(STEP_PERIODS - 1);
      logic [PW-1:0] per_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) per_cnt <= '0;
        else if (period_end) begin
          if (per_cnt == LAST) per_cnt <= '0;
          else                 per_cnt <= per_cnt + 1'b1;
        end
      end

      assign step = period_end && (per_cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/breath_ramp.sv
// Triangle duty generator: climbs to the top code, turns, falls to zero, turns.
module breath_ramp
  import breath_pwm_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [DUTY_W:0] duty
);
  localparam logic [DUTY_W:0] TOP      = (DUTY_W + 1)'(1) << DUTY_W;
  localparam logic [DUTY_W:0] BELOW_TOP = TOP - 1'b1;
  localparam logic [DUTY_W:0] ONE      = (DUTY_W + 1)'(1);

  ramp_dir_e dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty  <= '0;
      dir_q <= RAMP_UP;
    end else if (step) begin
      if (dir_q == RAMP_UP) begin
        duty <= duty + 1'b1;
        if (duty == BELOW_TOP) dir_q <= RAMP_DOWN;
      end else begin
        duty <= duty - 1'b1;
        if (duty == ONE) dir_q <= RAMP_UP;
      end
    end
  end
endmodule

// File: rtl/breath_pwm.sv
// Autonomous breathing LED modulator top.
module breath_pwm #(
  parameter int NUM_LED      = 4,
  parameter int CNT_W        = 11,
  parameter int DUTY_W       = 8,
  parameter int STEP_PERIODS = 72
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_LED-1:0] led
);
  localparam int SHIFT = CNT_W - DUTY_W;

  logic [CNT_W-1:0] carrier_cnt;
  logic             period_end;
  logic             step;
  logic [DUTY_W:0]  duty_code;
  logic [CNT_W:0]   threshold;
  logic             pulse_on;

  breath_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (carrier_cnt),
    .period_end (period_end)
  );

  breath_prescale #(.STEP_PERIODS(STEP_PERIODS)) u_prescale (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_end (period_end),
    .step       (step)
  );

  breath_ramp #(.DUTY_W(DUTY_W)) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .duty  (duty_code)
  );

  assign threshold = (CNT_W + 1)'(duty_code) << SHIFT;
  assign pulse_on  = {1'b0, carrier_cnt} < threshold;

  generate
    for (genvar i = 0; i < NUM_LED; i++) begin : g_led
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) led[i] <= 1'b0;
        else        led[i] <= pulse_on;
      end
    end
  endgenerate
endmodule

// File: rtl/breath_pwm_chk.sv
module breath_pwm_chk #(
  parameter int NUM_LED = 4,
  parameter int CNT_W   = 11,
  parameter int DUTY_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_LED-1:0] led,
  input logic [CNT_W-1:0]   cnt,
  input logic [DUTY_W:0]    duty
);
  localparam logic [DUTY_W:0] TOP = (DUTY_W + 1)'(1) << DUTY_W;

  a_r1_reset_dark: assert property (@(posedge clk)
    !rst_n |-> (led == '0));

  a_r8_leds_match: assert property (@(posedge clk) disable iff (!rst_n)
    (led == '0) || (led == '1));

  a_r6_duty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(duty));

  a_r7_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (duty != $past(duty)) |->
      ((duty == $past(duty) + 1'b1) || (duty + 1'b1 == $past(duty))));

  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    duty <= TOP);

  a_r5_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led[0]) |-> (cnt == CNT_W'(1)));
endmodule

bind breath_pwm breath_pwm_chk #(
  .NUM_LED (NUM_LED),
  .CNT_W   (CNT_W),
  .DUTY_W  (DUTY_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .led   (led),
  .cnt   (carrier_cnt),
  .duty  (duty_code)
);

// File: tb/breath_pwm_tb_top.sv
module breath_pwm_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int NL   = 4;
  localparam int CW   = 4;
  localparam int DW   = 2;
  localparam int PRE  = 2;
  localparam int P    = 1 << CW;
  localparam int DMAX = 1 << DW;
  localparam int UNIT = 1 << (CW - DW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] led;

  typedef struct {
    logic  lvl;
    string tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  breath_pwm #(
    .NUM_LED      (NL),
    .CNT_W        (CW),
    .DUTY_W       (DW),
    .STEP_PERIODS (PRE)
  ) dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .led   (led)
  );

  function automatic int tri_code(int s);
    int m = s % (2 * DMAX);
    return (m <= DMAX) ? m : 2 * DMAX - m;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: led act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: expected level after clock edge n (n >= 1) since reset release.
  task automatic drive_expected(int ncyc);
    for (int n = 1; n <= ncyc; n++) begin
      exp_t e;
      int pos = (n - 1) % P;
      int per = (n - 1) / P;
      int stp = per / PRE;
      int d   = tri_code(stp);
      e.lvl = (pos < d * UNIT);
      if (pos == 0 && per > 0 && per % PRE == 0) e.tag = "R6";
      else if (pos == 0)                         e.tag = "R2";
      else if (d == 0)                           e.tag = "R3";
      else if (d == DMAX)                        e.tag = "R4";
      else if (stp % (2 * DMAX) > DMAX)          e.tag = "R7";
      else                                       e.tag = "R5";
      q.push_back(e);
    end
  endtask

  // Monitor: pops one expected item per cycle, sampled at the falling edge.
  task automatic monitor(int ncyc);
    for (int n = 1; n <= ncyc; n++) begin
      exp_t e;
      @(negedge clk);
      e = q.pop_front();
      check(led[0] === e.lvl, e.tag, int'(led[0]), int'(e.lvl));
      check((led == '0) || (led == '1), "R8", int'(led), e.lvl ? (1 << NL) - 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: dark while held in reset
    repeat (4) begin
      @(negedge clk);
      check(led == '0, "R1", int'(led), 0);
    end
    rst_n = 1'b1;
    drive_expected(700);
    monitor(700);

    // R1: mid-run reset darkens outputs and restarts the ramp at code 0
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(led == '0, "R1", int'(led), 0);
    end
    rst_n = 1'b1;
    drive_expected(300);
    monitor(300);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule